// File: doc/BRIEF.md
# Per-Channel Pin Drive and Test Unit

This block controls a bank of bidirectional tester pins. Each line of a stimulus pattern gives every channel a 3-bit code. The code either drives the pin low or high, or releases it to its weak pull-down, or releases it and compares the pin against an expected high or low level, or sends the line clock out on the pin. The line clock arrives as a level on `line_clk`, synchronous to the system clock `clk`. `last_clk` marks the final line clock of the current line, and `running` is high while a pattern executes.

A new line's codes take effect on the falling edge of the last line clock of the previous line, or at the start of a run. Test channels are sampled on the rising edge of the last line clock. At that strobe, any mismatch produces a one-cycle fail pulse for the affected group of eight channels and a one-cycle per-line fail flag for the sequencer. The mismatch is also added to a sticky per-channel fail mask. Analog levels and pull-downs are modelled as logic values only: a released pin reads back as whatever the bench drives on `pin_in`.

Top module: `pin_ctrl_unit`

## Requirements
- R1: After synchronous reset, `pin_oe`, `pin_out`, `fail_grp_stb`, `line_fail` and `fail_mask` are all zero.
- R2: Code 0 drives the pin low and code 1 drives it high; in both cases `pin_oe` is 1 for that channel.
- R3: Code 2 (release), code 3 (test high), code 4 (test low) and the unused codes 6 and 7 give `pin_oe`=0 and `pin_out`=0.
- R4: Code 5 sets `pin_oe`=1, and `pin_out` follows `line_clk` in the same cycle.
- R5: `code_in` is loaded in the cycle where `running` first goes high, and in a cycle where `line_clk` falls while `last_clk` and `running` are high. The loaded code is visible after that clock edge. A falling edge with `last_clk` low leaves the applied codes unchanged.
- R6: A strobe occurs in a cycle where `line_clk` rises while `last_clk` and `running` are high. At a strobe, a code-3 channel fails if `pin_in` is 0, and a code-4 channel fails if `pin_in` is 1. A rising edge with `last_clk` low tests nothing.
- R7: Bit g of `fail_grp_stb` pulses for exactly one cycle, after the strobe edge, when any channel in 8g..8g+7 failed at that strobe.
- R8: `line_fail` pulses for one cycle, in the same cycle as the group strobes, when any channel failed at the strobe.
- R9: `fail_mask` bit i is set when channel i fails and stays set until reset.
- R10: While `running` is 0, every `pin_oe` bit is 0 in that same cycle, and no code load and no test takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| running | input | 1 | Pattern executing |
| line_clk | input | 1 | Line clock level |
| last_clk | input | 1 | Current line clock is the line's last |
| code_in | input | 48 | Next line's codes, 3 bits per channel, channel i at [3i+2:3i] |
| pin_in | input | 16 | Sensed pin levels |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin drive enables |
| fail_grp_stb | output | 2 | Per-group fail pulses |
| line_fail | output | 1 | Any test failed at this strobe |
| fail_mask | output | 16 | Accumulated failing channels |

## Verification
The bench builds the block with its default 16 channels in two groups of eight. This keeps both group strobes and their channel boundaries observable. Every one of the eight code values is rotated across all channels, with several pin patterns for each, so each code meets both pin levels in every channel position. Expected drive, enable, fail and mask values are computed arithmetically per channel. Separate lines cover non-last clock edges, the idle state and reset clearing of the mask.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] PC_DRV0 = 3'd0;
    localparam logic [CODE_W-1:0] PC_DRV1 = 3'd1;
    localparam logic [CODE_W-1:0] PC_HIZ  = 3'd2;
    localparam logic [CODE_W-1:0] PC_TSTH = 3'd3;
    localparam logic [CODE_W-1:0] PC_TSTL = 3'd4;
    localparam logic [CODE_W-1:0] PC_CLKO = 3'd5;

    typedef struct packed {
        logic en;
        logic val;
        logic use_clk;
    } drive_t;

    function automatic drive_t decode_drive(input logic [CODE_W-1:0] code);
        drive_t d;
        d = '0;
        case (code)
            PC_DRV0: d.en = 1'b1;
            PC_DRV1: begin d.en = 1'b1; d.val = 1'b1; end
            PC_CLKO: begin d.en = 1'b1; d.use_clk = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic logic test_miss(input logic [CODE_W-1:0] code,
                                       input logic pin);
        return ((code == PC_TSTH) && !pin) || ((code == PC_TSTL) && pin);
    endfunction

endpackage

// File: rtl/pin_line_timing.sv
module pin_line_timing (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic line_clk,
    input  logic last_clk,
    output logic load,
    output logic strobe
);
    logic clk_q;
    logic run_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            run_q <= 1'b0;
        end else begin
            clk_q <= line_clk;
            run_q <= running;
        end
    end

    assign rise   = line_clk & ~clk_q;
    assign fall   = ~line_clk & clk_q;
    assign load   = running & (~run_q | (fall & last_clk));
    assign strobe = running & rise & last_clk;
endmodule

// File: rtl/pin_cell.sv
module pin_cell
    import pin_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_nxt,
    input  logic              running,
    input  logic              line_clk,
    input  logic              strobe,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fail
);
    logic [CODE_W-1:0] code_q;
    drive_t            drv;

    always_ff @(posedge clk) begin
        if (rst)       code_q <= PC_HIZ;
        else if (load) code_q <= code_nxt;
    end

    always_comb begin
        drv     = decode_drive(code_q);
        pin_oe  = drv.en & running;
        pin_out = pin_oe & (drv.use_clk ? line_clk : drv.val);
        fail    = strobe & test_miss(code_q, pin_in);
    end
endmodule

// File: rtl/pin_fail_gather.sv
module pin_fail_gather #(
    parameter int NCH = 16,
    parameter int GRP = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       miss,
    output logic [NCH/GRP-1:0]   grp_stb,
    output logic                 line_fail,
    output logic [NCH-1:0]       mask
);
    localparam int NGRP = NCH / GRP;

    logic [NGRP-1:0] grp_hit;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_hit[g] = |miss[g*GRP +: GRP];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_stb   <= '0;
            line_fail <= 1'b0;
            mask      <= '0;
        end else begin
            grp_stb   <= grp_hit;
            line_fail <= |miss;
            mask      <= mask | miss;
        end
    end
endmodule

// File: rtl/pin_ctrl_unit.sv
module pin_ctrl_unit
    import pin_ctrl_pkg::*;
#(
    parameter int NCH = 16,
    parameter int GRP = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   running,
    input  logic                   line_clk,
    input  logic                   last_clk,
    input  logic [NCH*CODE_W-1:0]  code_in,
    input  logic [NCH-1:0]         pin_in,
    output logic [NCH-1:0]         pin_out,
    output logic [NCH-1:0]         pin_oe,
    output logic [NCH/GRP-1:0]     fail_grp_stb,
    output logic                   line_fail,
    output logic [NCH-1:0]         fail_mask
);
    logic           load;
    logic           strobe;
    logic [NCH-1:0] miss;

    pin_line_timing u_timing (
        .clk      (clk),
        .rst      (rst),
        .running  (running),
        .line_clk (line_clk),
        .last_clk (last_clk),
        .load     (load),
        .strobe   (strobe)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pin_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .code_nxt (code_in[i*CODE_W +: CODE_W]),
            .running  (running),
            .line_clk (line_clk),
            .strobe   (strobe),
            .pin_in   (pin_in[i]),
            .pin_out  (pin_out[i]),
            .pin_oe   (pin_oe[i]),
            .fail     (miss[i])
        );
    end

    pin_fail_gather #(.NCH(NCH), .GRP(GRP)) u_gather (
        .clk       (clk),
        .rst       (rst),
        .miss      (miss),
        .grp_stb   (fail_grp_stb),
        .line_fail (line_fail),
        .mask      (fail_mask)
    );
endmodule

// File: rtl/pin_ctrl_checker.sv
module pin_ctrl_checker #(
    parameter int NCH  = 16,
    parameter int NGRP = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            running,
    input logic            line_clk,
    input logic            last_clk,
    input logic [NCH-1:0]  pin_oe,
    input logic [NGRP-1:0] fail_grp_stb,
    input logic            line_fail,
    input logic [NCH-1:0]  fail_mask
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (fail_mask == '0 && line_fail == 1'b0 && fail_grp_stb == '0));

    p_idle_release_r10: assert property (@(posedge clk) disable iff (rst)
        !running |-> (pin_oe == '0));

    p_grp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (fail_grp_stb != '0) |=> (fail_grp_stb == '0));

    p_fail_agree_r8: assert property (@(posedge clk) disable iff (rst)
        line_fail |-> (fail_grp_stb != '0 && fail_mask != '0));

    p_strobe_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(line_fail) |-> $past(line_clk && last_clk && running));

    p_mask_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fail_mask & $past(fail_mask)) == $past(fail_mask)));
endmodule

bind pin_ctrl_unit pin_ctrl_checker #(.NCH(NCH), .NGRP(NCH/GRP)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .running      (running),
    .line_clk     (line_clk),
    .last_clk     (last_clk),
    .pin_oe       (pin_oe),
    .fail_grp_stb (fail_grp_stb),
    .line_fail    (line_fail),
    .fail_mask    (fail_mask)
);

// File: tb/pin_ctrl_unit_bench.sv
module pin_ctrl_unit_bench;
    localparam int NCH = 16;
    localparam int GRP = 8;
    localparam int NG  = NCH / GRP;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            running = 1'b0;
    logic            line_clk = 1'b0;
    logic            last_clk = 1'b0;
    logic [NCH*3-1:0] code_in = '0;
    logic [NCH-1:0]  pin_in = '0;
    logic [NCH-1:0]  pin_out;
    logic [NCH-1:0]  pin_oe;
    logic [NG-1:0]   fail_grp_stb;
    logic            line_fail;
    logic [NCH-1:0]  fail_mask;

    int checks = 0;
    int failures = 0;
    logic [NCH*3-1:0] cur_codes = '0;
    logic [NCH-1:0]   exp_mask = '0;

    pin_ctrl_unit #(.NCH(NCH), .GRP(GRP)) u_pin_ctrl_unit (
        .clk(clk), .rst(rst), .running(running), .line_clk(line_clk),
        .last_clk(last_clk), .code_in(code_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fail_grp_stb(fail_grp_stb),
        .line_fail(line_fail), .fail_mask(fail_mask)
    );

    always #5 clk = ~clk;

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog: run did not end (actual hung, expected done)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*3-1:0] rot_codes(input int k);
        logic [NCH*3-1:0] w;
        for (int i = 0; i < NCH; i++) w[i*3 +: 3] = 3'((i + k) % 8);
        return w;
    endfunction

    function automatic logic [NCH-1:0] exp_oe(input logic [NCH*3-1:0] w);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            int c = int'(w[i*3 +: 3]);
            r[i] = (c == 0) || (c == 1) || (c == 5);
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_out(input logic [NCH*3-1:0] w, input logic lc);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            int c = int'(w[i*3 +: 3]);
            r[i] = (c == 1) || ((c == 5) && lc);
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_miss(input logic [NCH*3-1:0] w, input logic [NCH-1:0] p);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            int c = int'(w[i*3 +: 3]);
            r[i] = ((c == 3) && !p[i]) || ((c == 4) && p[i]);
        end
        return r;
    endfunction

    function automatic logic [NG-1:0] grp_of(input logic [NCH-1:0] m);
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) r[g] = |m[g*GRP +: GRP];
        return r;
    endfunction

    // One line: fall of previous last clock loads codes, then the last rise strobes.
    task automatic run_line(input logic [NCH*3-1:0] w, input logic [NCH-1:0] p);
        logic [NCH-1:0] m;
        code_in  = w;
        last_clk = 1'b1;
        line_clk = 1'b0;
        tick();
        cur_codes = w;
        chk("R2 R3 oe", 64'(pin_oe), 64'(exp_oe(w)));
        chk("R2 R4 out low clk", 64'(pin_out), 64'(exp_out(w, 1'b0)));
        pin_in   = p;
        line_clk = 1'b1;
        tick();
        m = exp_miss(w, p);
        exp_mask = exp_mask | m;
        chk("R4 out high clk", 64'(pin_out), 64'(exp_out(w, 1'b1)));
        chk("R7 group strobe", 64'(fail_grp_stb), 64'(grp_of(m)));
        chk("R8 line fail", 64'(line_fail), 64'(|m));
        chk("R9 mask", 64'(fail_mask), 64'(exp_mask));
        tick();
        chk("R7 strobe one cycle", 64'(fail_grp_stb), 64'd0);
        chk("R8 line fail one cycle", 64'(line_fail), 64'd0);
    endtask

    initial begin
        logic [NCH-1:0] pats [4];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h0F0F;

        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 oe", 64'(pin_oe), 64'd0);
        chk("R1 out", 64'(pin_out), 64'd0);
        chk("R1 strobe", 64'(fail_grp_stb), 64'd0);
        chk("R1 line fail", 64'(line_fail), 64'd0);
        chk("R1 mask", 64'(fail_mask), 64'd0);

        // R10: idle with driving codes and active edges does nothing
        code_in = rot_codes(0);
        last_clk = 1'b1;
        line_clk = 1'b1; tick();
        line_clk = 1'b0; tick();
        chk("R10 idle oe", 64'(pin_oe), 64'd0);
        chk("R10 idle no test", 64'(fail_mask), 64'd0);

        // R5 start load: all channels drive high
        code_in = {NCH{3'd1}};
        running = 1'b1;
        last_clk = 1'b0;
        tick();
        chk("R5 start load oe", 64'(pin_oe), 64'(exp_oe(code_in)));
        chk("R5 start load out", 64'(pin_out), 64'hFFFF);
        line_clk = 1'b1;
        tick();

        // Sweep every code rotation against every pin pattern
        for (int k = 0; k < 8; k++) begin
            for (int q = 0; q < 4; q++) begin
                run_line(rot_codes(k), pats[q]);
            end
        end

        // R5/R6: non-last edges neither load nor test
        code_in  = {NCH{3'd3}};
        last_clk = 1'b0;
        line_clk = 1'b0; tick();
        chk("R5 no load on non-last fall", 64'(pin_oe), 64'(exp_oe(cur_codes)));
        pin_in = 16'h0000;
        line_clk = 1'b1; tick();
        chk("R6 no test on non-last rise", 64'(line_fail), 64'd0);
        chk("R6 mask unchanged", 64'(fail_mask), 64'(exp_mask));

        // Group boundary: only channel 8 fails
        run_line({ {7{3'd2}}, 3'd3, {8{3'd2}} }, 16'h0000);
        // Only channel 7 fails
        run_line({ {8{3'd2}}, 3'd4, {7{3'd2}} }, 16'h0080);

        // R10: running drops, oe released same cycle
        code_in = {NCH{3'd0}};
        run_line(code_in, 16'h0000);
        running = 1'b0;
        #1;
        chk("R10 oe released same cycle", 64'(pin_oe), 64'd0);
        tick();

        // R9 sticky until reset; R1 reset clears
        chk("R9 mask held", 64'(fail_mask), 64'(exp_mask));
        rst = 1'b1; tick();
        rst = 1'b0; exp_mask = '0;
        chk("R1 mask cleared by reset", 64'(fail_mask), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule